// File: doc/BRIEF.md
# SM4 Round-Serial Block Cipher Core

This core encrypts or decrypts a single 128-bit block by applying one SM4 round per clock cycle. A complete block takes 32 rounds. A caller offers a block with a direction bit on a valid/ready request port. The core iterates on that block and then presents the 128-bit result on a valid/ready response port. The result stays there until the caller takes it.

The core holds no key material. During each round it puts a round-key index on a 5-bit output. An external key store must return the matching 32-bit round key in the same cycle. Encryption and decryption run through the same round circuit and differ only in the order in which they fetch round keys.

The S-box bytes are not stored as a written table. The core builds them from the cipher's algebraic definition: an affine map, then an inversion in GF(2^8) modulo x^8+x^7+x^6+x^5+x^4+x^2+1, then the affine map again. The affine map uses the circulant row pattern 0xA7 and the constant 0xD3.

Top module: `sm4_iter_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `in_ready` is 1 and `out_valid` is 0.
- R2: `in_ready` is 1 only while the core holds no block and has no pending result. A block is taken on a clock edge where `in_valid` and `in_ready` are both 1. After that edge `in_ready` is 0.
- R3: The result is valid exactly 32 clock edges after the accepting edge. No idle cycles are inserted between rounds.
- R4: When `in_decrypt` is 0 at acceptance (encrypt), `rk_idx` steps 0, 1, …, 31 over the 32 round cycles, one value per cycle.
- R5: When `in_decrypt` is 1 at acceptance (decrypt), `rk_idx` steps 31, 30, …, 0 over the 32 round cycles.
- R6: The block is split into words X0..X3, with X0 in bits 127:96. Each round sets T = X1^X2^X3^rk and S = the byte-wise S-box of T. The new state is (X1, X2, X3, X0 ^ S ^ rotl(S,2) ^ rotl(S,10) ^ rotl(S,18) ^ rotl(S,24)). For the standard test vector, encrypting 0123456789abcdeffedcba9876543210 under the key 0123456789abcdeffedcba9876543210 gives 681edf34d206965e86b3e94f536e4246.
- R7: `out_data` carries the final state words in reverse order: the last word produced is in bits 127:96 and X0 of the final state is in bits 31:0.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values. After the edge where both are 1, the core is idle again, with `in_ready` 1 and `out_valid` 0.
- R9: Decrypting a block with the same round keys returns the original plaintext.
- R10: Values on `in_valid`, `in_data` and `in_decrypt` while the core is busy do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request: a block is offered |
| in_ready | output | 1 | Request: core is idle and can take a block |
| in_decrypt | input | 1 | Direction, 1 = decrypt, 0 = encrypt |
| in_data | input | 128 | Block to process, X0 in bits 127:96 |
| out_valid | output | 1 | Response: result is available |
| out_ready | input | 1 | Response: caller takes the result |
| out_data | output | 128 | Processed block with words reversed |
| rk_idx | output | 5 | Round-key index requested this cycle |
| rk_word | input | 32 | Round key returned by the key store for `rk_idx` |

## Verification
The bench builds the core with its default of 32 rounds. This is the only setting in which the published known-answer vector applies, so the ciphertext can be checked against an absolute value as well as against the bench's own model. The bench derives the round keys by running the key schedule itself. This lets it test the two key orders, the encrypt-then-decrypt round trip, the latency count, back-pressure on the result, and requests raised while a block is in flight.

// File: rtl/sm4_pkg.sv
package sm4_pkg;

  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int NWORDS  = 4;
  localparam int BLK_W   = WORD_W * NWORDS;
  localparam int NBYTES  = WORD_W / BYTE_W;
  localparam int SB_SIZE = 1 << BYTE_W;

  // Low byte of the field polynomial x^8+x^7+x^6+x^5+x^4+x^2+1
  localparam logic [7:0] GF_POLY_LO = 8'hF5;
  // First row of the circulant affine matrix and the affine constant
  localparam logic [7:0] AFF_ROW    = 8'hA7;
  localparam logic [7:0] AFF_CONST  = 8'hD3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } phase_t;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[7] ? ({sh[6:0], 1'b0} ^ GF_POLY_LO) : {sh[6:0], 1'b0};
    end
    return acc;
  endfunction

  // a^254 is the inverse of a, with 0 mapped to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] r;
    sq = a;
    r  = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] aff_map(input logic [7:0] x);
    logic [7:0]  y;
    logic [15:0] d;
    for (int i = 0; i < 8; i++) begin
      d    = {AFF_ROW, AFF_ROW} << i;
      y[i] = ^(x & d[15:8]);
    end
    return y;
  endfunction

  function automatic logic [7:0] sbox_calc(input logic [7:0] x);
    return aff_map(gf_inv(aff_map(x) ^ AFF_CONST)) ^ AFF_CONST;
  endfunction

  function automatic logic [WORD_W-1:0] rotl32(input logic [WORD_W-1:0] w, input int n);
    logic [2*WORD_W-1:0] d;
    d = {w, w} << n;
    return d[2*WORD_W-1:WORD_W];
  endfunction

  function automatic logic [WORD_W-1:0] lin_data(input logic [WORD_W-1:0] b);
    return b ^ rotl32(b, 2) ^ rotl32(b, 10) ^ rotl32(b, 18) ^ rotl32(b, 24);
  endfunction

endpackage

// File: rtl/sm4_sbox.sv
module sm4_sbox
  import sm4_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  output logic [BYTE_W-1:0] y_o
);

  logic [BYTE_W-1:0] tbl [SB_SIZE];

  for (genvar g = 0; g < SB_SIZE; g++) begin : g_ent
    assign tbl[g] = sbox_calc(BYTE_W'(g));
  end

  assign y_o = tbl[a_i];

endmodule

// File: rtl/sm4_round.sv
module sm4_round
  import sm4_pkg::*;
(
  input  logic [BLK_W-1:0]  st_i,
  input  logic [WORD_W-1:0] rk_i,
  output logic [BLK_W-1:0]  st_o
);

  logic [WORD_W-1:0] w0, w1, w2, w3;
  logic [WORD_W-1:0] mix;
  logic [WORD_W-1:0] sub;

  assign w0  = st_i[3*WORD_W +: WORD_W];
  assign w1  = st_i[2*WORD_W +: WORD_W];
  assign w2  = st_i[1*WORD_W +: WORD_W];
  assign w3  = st_i[0*WORD_W +: WORD_W];
  assign mix = w1 ^ w2 ^ w3 ^ rk_i;

  for (genvar b = 0; b < NBYTES; b++) begin : g_sub
    sm4_sbox u_sbox (
      .a_i (mix[b*BYTE_W +: BYTE_W]),
      .y_o (sub[b*BYTE_W +: BYTE_W])
    );
  end

  assign st_o = {w1, w2, w3, w0 ^ lin_data(sub)};

endmodule

// File: rtl/sm4_ctrl.sv
module sm4_ctrl
  import sm4_pkg::*;
#(
  parameter  int ROUNDS = 32,
  localparam int IDX_W  = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_decrypt,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             load_o,
  output logic             step_o,
  output logic [IDX_W-1:0] rk_idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS - 1);

  phase_t           ph_q, ph_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             dec_q, dec_d;
  logic             last;
  logic             cnt_en;

  assign in_ready  = (ph_q == PH_IDLE);
  assign out_valid = (ph_q == PH_DONE);
  assign load_o    = in_ready && in_valid;
  assign step_o    = (ph_q == PH_RUN);
  assign last      = (cnt_q == LAST);
  assign cnt_en    = load_o || step_o;
  assign rk_idx    = dec_q ? (LAST - cnt_q) : cnt_q;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    dec_d = dec_q;
    case (ph_q)
      PH_IDLE: begin
        if (in_valid) begin
          ph_d  = PH_RUN;
          cnt_d = '0;
          dec_d = in_decrypt;
        end
      end
      PH_RUN: begin
        cnt_d = cnt_q + IDX_W'(1);
        if (last) ph_d = PH_DONE;
      end
      PH_DONE: begin
        if (out_ready) ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      dec_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (load_o) dec_q <= dec_d;
    end
  end

  // R2: an accepted block closes the request port at once
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && !out_valid));

  // R3: the final round hands over to the result phase
  p_finish_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && last) |=> out_valid);

  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_decrypt) |=> (rk_idx == '0));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && !last && !dec_q) |=> (rk_idx == $past(rk_idx) + IDX_W'(1)));

  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_decrypt) |=> (rk_idx == LAST));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && !last && dec_q) |=> (rk_idx == $past(rk_idx) - IDX_W'(1)));

  // R8: a taken result returns the core to idle
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));

endmodule

// File: rtl/sm4_iter_core.sv
module sm4_iter_core
  import sm4_pkg::*;
#(
  parameter  int ROUNDS = 32,
  localparam int IDX_W  = $clog2(ROUNDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_decrypt,
  input  logic [BLK_W-1:0]   in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [BLK_W-1:0]   out_data,
  output logic [IDX_W-1:0]   rk_idx,
  input  logic [WORD_W-1:0]  rk_word
);

  logic             load;
  logic             step;
  logic             st_en;
  logic [BLK_W-1:0] st_q, st_d, rnd_out;

  sm4_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_decrypt (in_decrypt),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .load_o     (load),
    .step_o     (step),
    .rk_idx     (rk_idx)
  );

  sm4_round u_round (
    .st_i (st_q),
    .rk_i (rk_word),
    .st_o (rnd_out)
  );

  assign st_en = load || step;

  always_comb begin
    st_d = load ? in_data : rnd_out;
  end

  always_ff @(posedge clk) begin
    if (st_en) st_q <= st_d;
  end

  for (genvar k = 0; k < NWORDS; k++) begin : g_rev
    assign out_data[k*WORD_W +: WORD_W] = st_q[(NWORDS-1-k)*WORD_W +: WORD_W];
  end

  // R8: a pending result is frozen until the caller takes it
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/sm4_iter_core_tb.sv
`timescale 1ns/1ps
module sm4_iter_core_tb;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic         in_decrypt;
  logic [127:0] in_data;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] out_data;
  logic [4:0]   rk_idx;
  logic [31:0]  rk_word;

  logic [31:0]  ks [32];
  logic [7:0]   sb [256];
  int           checks;
  int           fails;
  longint       cyc;

  assign rk_word = ks[rk_idx];

  sm4_iter_core u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_decrypt (in_decrypt),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .rk_idx     (rk_idx),
    .rk_word    (rk_word)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------- independent cipher arithmetic ----------
  function automatic logic [7:0] t_gmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h1F5 << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] t_aff(input logic [7:0] x);
    logic [7:0] row;
    logic [7:0] y;
    for (int i = 0; i < 8; i++) begin
      case (i)
        0: row = 8'hA7; 1: row = 8'h4F; 2: row = 8'h9E; 3: row = 8'h3D;
        4: row = 8'h7A; 5: row = 8'hF4; 6: row = 8'hE9; default: row = 8'hD3;
      endcase
      y[i] = ^(x & row);
    end
    return y;
  endfunction

  function automatic logic [31:0] rl(input logic [31:0] w, input int n);
    return (w << n) | (w >> (32 - n));
  endfunction

  function automatic logic [31:0] tau(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  function automatic logic [31:0] f_data(input logic [31:0] t);
    logic [31:0] s;
    s = tau(t);
    return s ^ rl(s, 2) ^ rl(s, 10) ^ rl(s, 18) ^ rl(s, 24);
  endfunction

  function automatic logic [31:0] f_key(input logic [31:0] t);
    logic [31:0] s;
    s = tau(t);
    return s ^ rl(s, 13) ^ rl(s, 23);
  endfunction

  task automatic expand_key(input logic [127:0] mk);
    logic [31:0] k [36];
    logic [31:0] ck;
    k[0] = mk[127:96] ^ 32'ha3b1bac6;
    k[1] = mk[95:64]  ^ 32'h56aa3350;
    k[2] = mk[63:32]  ^ 32'h677d9197;
    k[3] = mk[31:0]   ^ 32'hb27022dc;
    for (int i = 0; i < 32; i++) begin
      ck = {8'((4*i)*7), 8'((4*i+1)*7), 8'((4*i+2)*7), 8'((4*i+3)*7)};
      k[i+4] = k[i] ^ f_key(k[i+1] ^ k[i+2] ^ k[i+3] ^ ck);
      ks[i] = k[i+4];
    end
  endtask

  function automatic logic [127:0] crypt(input logic [127:0] blk, input bit dec);
    logic [31:0] x [4];
    logic [31:0] nw;
    x[0] = blk[127:96]; x[1] = blk[95:64]; x[2] = blk[63:32]; x[3] = blk[31:0];
    for (int i = 0; i < 32; i++) begin
      nw = x[0] ^ f_data(x[1] ^ x[2] ^ x[3] ^ ks[dec ? 31 - i : i]);
      x[0] = x[1]; x[1] = x[2]; x[2] = x[3]; x[3] = nw;
    end
    return {x[3], x[2], x[1], x[0]};
  endfunction

  // ---------- cycle reference model ----------
  bit          m_busy, m_done, m_dec;
  int          m_cnt;
  logic [31:0] m_x [4];
  logic [31:0] m_nw;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_dec = 0; m_cnt = 0;
    end else if (!m_busy && !m_done) begin
      if (in_valid) begin
        m_busy = 1; m_cnt = 0; m_dec = in_decrypt;
        m_x[0] = in_data[127:96]; m_x[1] = in_data[95:64];
        m_x[2] = in_data[63:32];  m_x[3] = in_data[31:0];
      end
    end else if (m_busy) begin
      m_nw = m_x[0] ^ f_data(m_x[1] ^ m_x[2] ^ m_x[3] ^ ks[m_dec ? 31 - m_cnt : m_cnt]);
      m_x[0] = m_x[1]; m_x[1] = m_x[2]; m_x[2] = m_x[3]; m_x[3] = m_nw;
      m_cnt++;
      if (m_cnt == 32) begin m_busy = 0; m_done = 1; end
    end else if (out_ready) begin
      m_done = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(in_ready == (!m_busy && !m_done), "R2 in_ready", 128'(in_ready), 128'(!m_busy && !m_done));
      chk(out_valid == m_done, "R3 out_valid", 128'(out_valid), 128'(m_done));
      if (m_busy) begin
        if (m_dec) chk(rk_idx == 5'(31 - m_cnt), "R5 rk_idx", 128'(rk_idx), 128'(31 - m_cnt));
        else       chk(rk_idx == 5'(m_cnt),      "R4 rk_idx", 128'(rk_idx), 128'(m_cnt));
      end
      if (m_done)
        chk(out_data == {m_x[3], m_x[2], m_x[1], m_x[0]}, "R7 out_data",
            out_data, {m_x[3], m_x[2], m_x[1], m_x[0]});
    end
  end

  // ---------- stimulus tasks ----------
  task automatic send(input logic [127:0] d, input bit dec, output longint c0);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_decrypt = dec;
    while (!in_ready) @(negedge clk);
    c0 = cyc;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic recv(input logic [127:0] exp, input string req, input longint c0);
    out_ready = 1'b1;
    while (!out_valid) @(negedge clk);
    chk(cyc == c0 + 33, "R3 latency", 128'(cyc - c0 - 1), 128'(32));
    chk(out_data == exp, req, out_data, exp);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [127:0] pt, ct, exp, held;
    longint c0;
    logic [7:0] a, inv;
    checks = 0; fails = 0; cyc = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_decrypt = 1'b0; in_data = '0; out_ready = 1'b0;
    for (int x = 0; x < 256; x++) ks[x % 32] = '0;

    for (int x = 0; x < 256; x++) begin
      a = t_aff(8'(x)) ^ 8'hD3;
      inv = 8'h00;
      for (int y = 1; y < 256; y++) if (t_gmul(a, 8'(y)) == 8'h01) inv = 8'(y);
      sb[x] = t_aff(inv) ^ 8'hD3;
    end

    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset outputs", {in_ready, out_valid}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 after release", {in_ready, out_valid}, 2'b10);

    // Known-answer encryption (R6, R7, R4)
    pt = 128'h0123456789abcdeffedcba9876543210;
    expand_key(pt);
    send(pt, 1'b0, c0);
    recv(128'h681edf34d206965e86b3e94f536e4246, "R6 known answer", c0);

    // Decrypt the known answer (R5, R9)
    send(128'h681edf34d206965e86b3e94f536e4246, 1'b1, c0);
    recv(pt, "R9 round trip", c0);

    // Random keys and blocks, both directions
    for (int n = 0; n < 6; n++) begin
      expand_key({$urandom, $urandom, $urandom, $urandom});
      pt = {$urandom, $urandom, $urandom, $urandom};
      ct = crypt(pt, 1'b0);
      send(pt, 1'b0, c0);
      recv(ct, "R6 random encrypt", c0);
      send(ct, 1'b1, c0);
      recv(pt, "R9 random decrypt", c0);
    end

    // Back-pressure on the result (R8)
    pt = {$urandom, $urandom, $urandom, $urandom};
    exp = crypt(pt, 1'b0);
    send(pt, 1'b0, c0);
    while (!out_valid) @(negedge clk);
    held = out_data;
    for (int h = 0; h < 6; h++) begin
      @(negedge clk);
      chk(out_valid == 1'b1 && out_data == held, "R8 hold", out_data, held);
      chk(in_ready == 1'b0, "R8 no new block", 128'(in_ready), 128'(0));
    end
    chk(held == exp, "R8 held value", held, exp);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R8 idle after take", {in_ready, out_valid}, 2'b10);

    // Requests while busy are ignored (R10)
    pt = {$urandom, $urandom, $urandom, $urandom};
    exp = crypt(pt, 1'b1);
    send(pt, 1'b1, c0);
    for (int j = 0; j < 12; j++) begin
      in_valid = 1'b1; in_decrypt = 1'($urandom); in_data = {$urandom, $urandom, $urandom, $urandom};
      @(negedge clk);
    end
    in_valid = 1'b0;
    recv(exp, "R10 busy requests ignored", c0);

    // Request held high across completion: next block waits for the take (R2)
    pt = {$urandom, $urandom, $urandom, $urandom};
    send(pt, 1'b0, c0);
    in_valid = 1'b1; in_data = ~pt; in_decrypt = 1'b0;
    while (!out_valid) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(out_data == crypt(pt, 1'b0), "R2 first result kept", out_data, crypt(pt, 1'b0));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    c0 = cyc;
    @(negedge clk);
    in_valid = 1'b0;
    recv(crypt(~pt, 1'b0), "R2 second block", c0);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule